// File: doc/BRIEF.md
# E1 Multi-Mode Test Pattern Generator

This block is the per-channel bit-serial test pattern source of an E1 line interface. When it is enabled it sends one of three patterns, and it keeps sending that pattern until the mode field returns to the off code. The first pattern is a pseudo-random sequence of length 2^11-1, 2^15-1 or 2^20-1. The 2^20-1 choice is a quasi-random variant that caps runs of zeros. The second pattern is a 24-bit user word sent over and over. The third is an in-band loopback code of 3 to 8 bits taken from an 8-bit content field. The block emits one bit on every clock where the bit enable is high. All its controls arrive as plain input ports.

In the pseudo-random and user-word patterns, the controller can corrupt exactly one bit on a rising edge of the error request, and it can complement the whole stream. While the block is off, its output carries the alarm indication request (all ones when requested). When any pattern is active, the pattern replaces that alarm output. Line coding, clock choice and pattern detection belong to other blocks.

Top module: `e1_test_pattern_gen`

## Requirements
- R1: With `gen_mode` = 00 the block is off: `gen_active` is 0 and `bit_out` equals `ais_req` (1 for the all-ones alarm, 0 otherwise).
- R2: `gen_mode` = 01 with `prbs_len_sel` = 00 sends the sequence a(m) = a(m-11) XOR a(m-9). Its first 11 bits are ones.
- R3: `gen_mode` = 01 with `prbs_len_sel` = 01 sends a(m) = a(m-15) XOR a(m-14). Its first 15 bits are ones.
- R4: `gen_mode` = 01 with `prbs_len_sel` = 10 or 11 sends a(m) = a(m-20) XOR a(m-17), starting with 20 ones. An emitted bit is forced to 1 whenever the 14 bits emitted before it were all 0, so no run of zeros is longer than 14.
- R5: `gen_mode` = 10 sends `arb_word` MSB first, starting at bit 23, and repeats every 24 bits.
- R6: `gen_mode` = 11 sends `lb_code` MSB first, starting at bit L-1, and repeats every L bits. L is `lb_len` clamped to the range 3..8: values 0 to 2 give 3, and values above 8 give 8.
- R7: The pattern advances only on clocks with `bit_en` high. The bit presented while `bit_en` is high is the bit emitted. While `bit_en` is low the output holds.
- R8: A rising edge of `err_inject` in mode 01 or 10 complements exactly the next emitted bit. Holding `err_inject` high causes no further errors.
- R9: An `err_inject` edge that arrives in mode 00 or 11 is discarded. It corrupts no later bit.
- R10: `invert_en` complements the stream in modes 01 and 10. It has no effect in mode 11.
- R11: While a pattern is active, `ais_req` has no effect on `bit_out`.
- R12: A change of `gen_mode` or `prbs_len_sel` restarts the selected pattern at its first bit. The first bit is presented in the cycle after the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_en | input | 1 | One-bit advance enable |
| gen_mode | input | 2 | 00 off, 01 pseudo-random, 10 user word, 11 loopback code |
| prbs_len_sel | input | 2 | 00 2^11-1, 01 2^15-1, 1x 2^20-1 quasi-random |
| arb_word | input | 24 | Repeating user word |
| lb_code | input | 8 | Loopback code content |
| lb_len | input | 4 | Loopback code length in bits |
| err_inject | input | 1 | Single-bit error request (rising edge) |
| invert_en | input | 1 | Complement the stream |
| ais_req | input | 1 | Alarm (all-ones) request used while off |
| bit_out | output | 1 | Serial output bit |
| gen_active | output | 1 | A pattern is being sent |

## Verification
`bit_out` is a combinational function of state that updates at a clock edge. The bench therefore drives every input at the falling edge and samples one time unit later: the sampled value is the bit emitted at the next rising edge. A mode or length-select change costs one clock with `bit_en` low, and the first pattern bit is checked in the cycle after it (R12). An error request is raised one edge before the bit it corrupts, so the corrupted bit is the first sample taken after the request is raised. Hold windows with `bit_en` low are sampled every cycle and must show the bit that is still pending.

// File: rtl/e1_test_pattern_gen.sv
module e1_test_pattern_gen #(
  parameter int ARB_W      = 24,
  parameter int LB_W       = 8,
  parameter int LB_MIN     = 3,
  parameter int QRSS_ZMAX  = 14,
  parameter int LFSR_W     = 20
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          bit_en,
  input  logic [1:0]                    gen_mode,
  input  logic [1:0]                    prbs_len_sel,
  input  logic [ARB_W-1:0]              arb_word,
  input  logic [LB_W-1:0]               lb_code,
  input  logic [$clog2(LB_W):0]         lb_len,
  input  logic                          err_inject,
  input  logic                          invert_en,
  input  logic                          ais_req,
  output logic                          bit_out,
  output logic                          gen_active
);
  localparam int ARB_IW = $clog2(ARB_W);
  localparam int LB_IW  = $clog2(LB_W);
  localparam int LB_LW  = LB_IW + 1;
  localparam int ZR_W   = $clog2(QRSS_ZMAX + 2);
  localparam logic [1:0] M_OFF = 2'b00, M_PRBS = 2'b01, M_ARB = 2'b10, M_LB = 2'b11;
  localparam logic [ARB_IW-1:0] ARB_TOP = ARB_IW'(ARB_W - 1);

  logic [1:0]        mode_q, sel_q;
  logic [LFSR_W-1:0] lfsr;
  logic [ZR_W-1:0]   zrun;
  logic [ARB_IW-1:0] arb_idx;
  logic [LB_IW-1:0]  lb_idx;
  logic              err_q, err_pend;
  logic              prbs_fb, prbs_raw, prbs_bit, pat;
  logic [LB_LW-1:0]  lb_eff, lb_top;

  wire is_qrss = prbs_len_sel[1];
  wire restart = (gen_mode == M_OFF) || (gen_mode != mode_q) || (prbs_len_sel != sel_q);
  wire err_ok  = (gen_mode == M_PRBS) || (gen_mode == M_ARB);
  wire err_rise = err_inject & ~err_q;

  always_comb begin
    case (prbs_len_sel)
      2'b00:   begin prbs_fb = lfsr[10] ^ lfsr[8];  prbs_raw = lfsr[10]; end
      2'b01:   begin prbs_fb = lfsr[14] ^ lfsr[13]; prbs_raw = lfsr[14]; end
      default: begin prbs_fb = lfsr[19] ^ lfsr[16]; prbs_raw = lfsr[19]; end
    endcase
  end

  assign prbs_bit = (is_qrss && zrun >= ZR_W'(QRSS_ZMAX)) ? 1'b1 : prbs_raw;

  always_comb begin
    if (lb_len < LB_LW'(LB_MIN))     lb_eff = LB_LW'(LB_MIN);
    else if (lb_len > LB_LW'(LB_W))  lb_eff = LB_LW'(LB_W);
    else                             lb_eff = lb_len;
  end
  assign lb_top = lb_eff - 1'b1;

  always_comb begin
    case (gen_mode)
      M_PRBS:  pat = prbs_bit;
      M_ARB:   pat = arb_word[arb_idx];
      M_LB:    pat = lb_code[lb_idx];
      default: pat = 1'b0;
    endcase
  end

  assign gen_active = (gen_mode != M_OFF);
  assign bit_out = gen_active ? (pat ^ (err_ok & (invert_en ^ err_pend))) : ais_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= M_OFF;
      sel_q   <= 2'b00;
      lfsr    <= '1;
      zrun    <= '0;
      arb_idx <= ARB_TOP;
      lb_idx  <= '0;
    end else begin
      mode_q <= gen_mode;
      sel_q  <= prbs_len_sel;
      if (restart) begin
        lfsr    <= '1;
        zrun    <= '0;
        arb_idx <= ARB_TOP;
        lb_idx  <= lb_top[LB_IW-1:0];
      end else if (bit_en) begin
        if (gen_mode == M_PRBS) begin
          lfsr <= {lfsr[LFSR_W-2:0], prbs_fb};
          zrun <= prbs_bit ? '0 : zrun + 1'b1;
        end
        arb_idx <= (arb_idx == '0) ? ARB_TOP : arb_idx - 1'b1;
        lb_idx  <= (lb_idx == '0) ? lb_top[LB_IW-1:0] : lb_idx - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q    <= 1'b0;
      err_pend <= 1'b0;
    end else begin
      err_q <= err_inject;
      if (err_rise && err_ok)      err_pend <= 1'b1;
      else if (!err_ok || bit_en)  err_pend <= 1'b0;
    end
  end
endmodule

// File: rtl/e1_test_pattern_gen_chk.sv
module e1_test_pattern_gen_chk #(
  parameter int ARB_W = 24,
  parameter int LB_W  = 8,
  parameter int ZMAX  = 14
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       bit_en,
  input logic [1:0]                 gen_mode,
  input logic [1:0]                 prbs_len_sel,
  input logic [LB_W-1:0]            lb_code,
  input logic [$clog2(LB_W):0]      lb_len,
  input logic                       err_inject,
  input logic                       bit_out,
  input logic                       err_pend,
  input logic [$clog2(ZMAX+2)-1:0]  zrun,
  input logic [$clog2(ARB_W)-1:0]   arb_idx
);
  AST_HOLD_WITHOUT_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_mode == 2'b11 && $past(gen_mode) == 2'b11 && $past(gen_mode, 2) == 2'b11 &&
     !$past(bit_en) && $stable(lb_code) && $stable(lb_len)) |-> $stable(bit_out)); // R7

  AST_ERR_ONESHOT: assert property (@(posedge clk) disable iff (!rst_n)
    (err_pend && bit_en && !err_inject) |=> !err_pend); // R8

  AST_ERR_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_mode == 2'b00 || gen_mode == 2'b11) |=> !err_pend); // R9

  AST_ZERO_RUN_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    zrun <= ($clog2(ZMAX+2))'(ZMAX)); // R4

  AST_ARB_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && gen_mode == 2'b10 && $past(gen_mode) == 2'b10 && $stable(prbs_len_sel) &&
     arb_idx == '0) |=> arb_idx == ($clog2(ARB_W))'(ARB_W - 1)); // R5
endmodule

bind e1_test_pattern_gen e1_test_pattern_gen_chk #(.ARB_W(ARB_W), .LB_W(LB_W), .ZMAX(QRSS_ZMAX)) u_chk (
  .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .gen_mode(gen_mode), .prbs_len_sel(prbs_len_sel),
  .lb_code(lb_code), .lb_len(lb_len), .err_inject(err_inject), .bit_out(bit_out),
  .err_pend(err_pend), .zrun(zrun), .arb_idx(arb_idx));

// File: tb/e1_test_pattern_gen_test.sv
module e1_test_pattern_gen_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, bit_en = 1'b0;
  logic [1:0] gen_mode = 2'b00, prbs_len_sel = 2'b00;
  logic [23:0] arb_word = '0;
  logic [7:0] lb_code = '0;
  logic [3:0] lb_len = 4'd3;
  logic err_inject = 1'b0, invert_en = 1'b0, ais_req = 1'b0;
  logic bit_out, gen_active;
  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  e1_test_pattern_gen uut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .gen_mode(gen_mode), .prbs_len_sel(prbs_len_sel),
    .arb_word(arb_word), .lb_code(lb_code), .lb_len(lb_len), .err_inject(err_inject),
    .invert_en(invert_en), .ais_req(ais_req), .bit_out(bit_out), .gen_active(gen_active));

  task automatic check(input logic got, input logic exp, input string req);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0b expected %0b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic emit(input logic exp, input string req);
    @(negedge clk); bit_en = 1'b1; #1; check(bit_out, exp, req);
  endtask

  task automatic hold(input logic exp, input string req);
    @(negedge clk); bit_en = 1'b0; #1; check(bit_out, exp, req);
  endtask

  task automatic set_mode(input logic [1:0] m, input logic [1:0] s);
    @(negedge clk); bit_en = 1'b0; gen_mode = m; prbs_len_sel = s;
  endtask

  task automatic run_prbs(input int n, input int k, input int count, input bit qrss,
                          input logic inv, input string req);
    logic [19:0] w = '1;
    int zr = 0, maxrun = 0;
    logic a, q;
    for (int m = 0; m < count; m++) begin
      a = (m < n) ? 1'b1 : (w[n-1] ^ w[k-1]);
      w = {w[18:0], a};
      q = (qrss && zr >= 14) ? 1'b1 : a;
      zr = q ? 0 : zr + 1;
      if (zr > maxrun) maxrun = zr;
      emit(q ^ inv, req);
    end
    if (qrss) begin
      n_chk++;
      if (maxrun > 14) begin
        n_bad++;
        $display("FAIL R4: longest zero run %0d expected <= 14", maxrun);
      end
    end
  endtask

  task automatic run_arb(input logic [23:0] wd, input int count, input logic inv, input bit gaps);
    logic e;
    for (int t = 0; t < count; t++) begin
      e = wd[23 - (t % 24)] ^ inv;
      if (gaps && (t % 5 == 4)) begin
        hold(e, "R7"); hold(e, "R7");
      end
      emit(e, inv ? "R10" : "R5");
    end
  endtask

  task automatic run_lb(input logic [7:0] code, input int lv, input int count);
    int L;
    L = (lv < 3) ? 3 : (lv > 8) ? 8 : lv;
    for (int t = 0; t < count; t++) emit(code[L - 1 - (t % L)], "R6");
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check(bit_out, 1'b0, "R1");
    check(gen_active, 1'b0, "R1");
    ais_req = 1'b1; #1;
    check(bit_out, 1'b1, "R1");

    // R2 / R11: alarm request stays high while pattern runs
    set_mode(2'b01, 2'b00);
    @(negedge clk); #1; check(gen_active, 1'b1, "R11");
    run_prbs(11, 9, 4200, 1'b0, 1'b0, "R2");
    // R3 and R12: select change restarts with seed ones
    set_mode(2'b01, 2'b01);
    run_prbs(15, 14, 5000, 1'b0, 1'b0, "R3");
    set_mode(2'b01, 2'b10);
    run_prbs(20, 17, 40000, 1'b1, 1'b0, "R4");
    set_mode(2'b01, 2'b11);
    run_prbs(20, 17, 200, 1'b1, 1'b0, "R4");
    // R10: inversion in pseudo-random mode
    invert_en = 1'b1;
    set_mode(2'b01, 2'b00);
    run_prbs(11, 9, 300, 1'b0, 1'b1, "R10");
    invert_en = 1'b0;

    // R5 with R7 hold gaps and R11 alarm overridden
    set_mode(2'b10, 2'b00);
    arb_word = 24'hA5C3F0;
    run_arb(24'hA5C3F0, 72, 1'b0, 1'b1);
    foreach (arb_word[i]) begin
      if (i % 6 == 0) begin
        arb_word = 24'h000001 << i;
        set_mode(2'b00, 2'b00);
        set_mode(2'b10, 2'b00);
        run_arb(24'h000001 << i, 48, 1'b0, 1'b0);
      end
    end
    arb_word = 24'h000000;
    set_mode(2'b00, 2'b00); set_mode(2'b10, 2'b00);
    run_arb(24'h000000, 24, 1'b0, 1'b0); // R11: output 0 despite alarm
    arb_word = 24'h3E91D7;
    invert_en = 1'b1;
    set_mode(2'b00, 2'b00); set_mode(2'b10, 2'b00);
    run_arb(24'h3E91D7, 48, 1'b1, 1'b0);
    invert_en = 1'b0;

    // R12: restart mid-word
    set_mode(2'b00, 2'b00); set_mode(2'b10, 2'b00);
    run_arb(24'h3E91D7, 10, 1'b0, 1'b0);
    set_mode(2'b01, 2'b00);
    run_prbs(11, 9, 5, 1'b0, 1'b0, "R12");
    set_mode(2'b10, 2'b00);
    run_arb(24'h3E91D7, 30, 1'b0, 1'b0);

    // R8: error insertion in user-word mode
    arb_word = 24'h0F0F0F;
    set_mode(2'b00, 2'b00); set_mode(2'b10, 2'b00);
    for (int t = 0; t < 5; t++) emit(arb_word[23 - t], "R8");
    @(negedge clk); bit_en = 1'b0; err_inject = 1'b1;
    emit(~arb_word[18], "R8");
    for (int t = 6; t < 40; t++) emit(arb_word[23 - (t % 24)], "R8");
    @(negedge clk); bit_en = 1'b0; err_inject = 1'b0;
    // R8: error insertion in pseudo-random mode
    set_mode(2'b01, 2'b00);
    for (int t = 0; t < 3; t++) emit(1'b1, "R8");
    @(negedge clk); bit_en = 1'b0; err_inject = 1'b1;
    emit(1'b0, "R8");
    for (int t = 4; t < 11; t++) emit(1'b1, "R8");
    @(negedge clk); bit_en = 1'b0; err_inject = 1'b0;

    // R9: request while off is dropped
    set_mode(2'b00, 2'b00);
    @(negedge clk); err_inject = 1'b1;
    @(negedge clk); err_inject = 1'b0;
    set_mode(2'b10, 2'b00);
    run_arb(24'h0F0F0F, 24, 1'b0, 1'b0);

    // R6: loopback length sweep, clamping
    for (int lv = 0; lv < 16; lv++) begin
      lb_len = 4'(lv);
      lb_code = 8'hB5 ^ 8'(lv * 37);
      set_mode(2'b00, 2'b00); set_mode(2'b11, 2'b00);
      run_lb(lb_code, lv, 20);
    end
    // R9 / R10: error edge and inversion ignored in loopback mode
    lb_len = 4'd5; lb_code = 8'h16;
    set_mode(2'b00, 2'b00); set_mode(2'b11, 2'b00);
    invert_en = 1'b1;
    @(negedge clk); err_inject = 1'b1;
    run_lb(8'h16, 5, 15);
    err_inject = 1'b0; invert_en = 1'b0;
    // R7: hold in loopback mode
    set_mode(2'b00, 2'b00); set_mode(2'b11, 2'b00);
    emit(1'b1, "R6"); hold(1'b0, "R7"); hold(1'b0, "R7"); emit(1'b0, "R7"); emit(1'b1, "R7");

    // R1: back to off, alarm follows request
    set_mode(2'b00, 2'b00);
    @(negedge clk); #1; check(bit_out, 1'b1, "R1"); check(gen_active, 1'b0, "R1");
    ais_req = 1'b0; #1; check(bit_out, 1'b0, "R1");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule